// File: doc/BRIEF.md
# Clause 22 management-bus master with register bank

This block lets software reach external PHY registers over the two-wire management bus (MDC clock, MDIO data). Software talks to it through a small bank of 32-bit registers on a word-addressed bus with one-cycle write strobes and registered reads. One 32-bit command word carries all of a transfer: the operation, the PHY and register addresses, and the write data. The block holds that word in a single queue slot. It then serialises a full Clause 22 frame, and for a read it collects the sixteen returned bits and a failure flag.

A status register tells software two things. One bit shows that a command is waiting for the wire. The other shows that a frame is being shifted. Software issues a new command only once the waiting bit is low, and it reads the result only once the shifting bit is low. A prescale field sets the MDC rate. The MDC period is 2×(N+1) system clocks. The value is captured when each frame begins.

Top module: `mdio_master`

## Requirements
- R1: After reset the status and data registers read zero, the prescale field reads 4, MDC is low and MDIO output enable is low.
- R2: Registers are selected by word index: 0 status (bit 2 = command waiting, bit 3 = frame in progress), 2 command, 3 read result, 4 configuration. Any other index reads zero. Read data appears on `bus_rdata` one clock after the `bus_rd` strobe.
- R3: A command write is accepted only when bit 31 is 1 and exactly one of bit 1 (write) and bit 2 (read) is 1. The PHY address is in bits 29:25, the register address in bits 24:20 and the write data in bits 19:4. Any other command word is ignored and no frame follows it. The command register reads back the last accepted command.
- R4: A command write that arrives while a command is already waiting is ignored. The waiting command and its readback are unchanged.
- R5: A waiting command starts as soon as no frame is in progress, and its waiting bit clears when it starts. A command accepted during a frame stays waiting until that frame ends and then runs.
- R6: Each frame is 64 MDC periods, sent MSB first: 32 ones, start 01, opcode (10 read, 01 write), 5-bit PHY address, 5-bit register address, turnaround, 16 data bits. On a write the turnaround is 10, the data is the command's write data, and output enable stays high for all 64 bits.
- R7: On a read, output enable drops from bit 46 (first turnaround bit) to the end of the frame. MDIO is sampled on each MDC rising edge, and the 16 data bits land in result bits 15:0.
- R8: On a read, if MDIO is high at the second turnaround bit, result bits 17:16 are both 1. The whole result register clears to zero when any command starts.
- R9: MDC is low whenever no frame is in progress. During a frame each MDC high phase lasts N+1 system clocks, where N is the prescale value captured at frame start.
- R10: Configuration bits 7:0 hold the prescale value N. A write whose bits 7:0 are zero leaves the value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| mdc | output | 1 | Management bus clock |
| mdio_o | output | 1 | Data driven onto MDIO |
| mdio_oe | output | 1 | MDIO output enable (high = drive) |
| mdio_i | input | 1 | Data sampled from MDIO |

## Verification
A bad bit counter or shift register shows at the pins within one MDC period. A wrong preamble, opcode or address bit appears at the rising edge where it is sampled. An early or late output release breaks the enable pattern at bit 46. A bad prescale capture changes the number of clocks MDC stays high in every period of the frame. Errors in the queue slot show up differently. A dropped or overwritten waiting command is visible only when its frame finishes, as a missing frame or a frame with the wrong fields. A stuck waiting bit shows on the next status read, and an extra frame makes MDC toggle while the bus should be idle.

// File: rtl/mdio_pkg.sv
// Shared constants and types for the management-bus master.
// Assumes a 64-bit Clause 22 frame and 32-bit register words.
package mdio_pkg;
    localparam int PRESC_W     = 8;
    localparam int DATA_W      = 16;
    localparam int PHY_W       = 5;
    localparam int REG_W       = 5;
    localparam int PRE_LEN     = 32;
    localparam int FRAME_LEN   = 64;
    localparam int REL_IDX     = 46;  // first turnaround bit
    localparam int TA2_IDX     = 47;  // second turnaround bit
    localparam int DAT_IDX     = 48;  // first data bit
    localparam int AW          = 3;

    localparam logic [AW-1:0] A_STATUS = 3'd0;
    localparam logic [AW-1:0] A_CMD    = 3'd2;
    localparam logic [AW-1:0] A_DATA   = 3'd3;
    localparam logic [AW-1:0] A_CFG    = 3'd4;

    localparam logic [PRESC_W-1:0] PRESC_RST = 8'd4;

    typedef struct packed {
        logic              rd;
        logic [PHY_W-1:0]  phy;
        logic [REG_W-1:0]  regad;
        logic [DATA_W-1:0] wdata;
    } mdio_cmd_t;
endpackage

// File: rtl/mdio_regbank.sv
// Register bank and single-entry command slot.
// Decodes bus writes, validates command words, holds the prescale value,
// and keeps the read result. Assumes one bus access per strobe.
module mdio_regbank
    import mdio_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [AW-1:0]      bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               eng_busy,
    input  logic               eng_done_rd,
    input  logic               eng_err,
    input  logic [DATA_W-1:0]  eng_rdata,
    output logic               start,
    output mdio_cmd_t          cmd,
    output logic [PRESC_W-1:0] prescale
);
    localparam int RES_W = DATA_W + 2;

    logic             pending;
    logic [RES_W-1:0] result_q;
    logic [31:0]      rd_mux;
    logic             cmd_ok;
    logic             unused_bits;

    assign unused_bits = ^{bus_wdata[30], bus_wdata[3], bus_wdata[0]};
    assign cmd_ok = bus_wdata[31] && (bus_wdata[1] ^ bus_wdata[2]);
    assign start  = pending && !eng_busy;

    // Queue slot: accept a well-formed command only when the slot is empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            cmd     <= '0;
        end else if (start) begin
            pending <= 1'b0;
        end else if (bus_wr && bus_addr == A_CMD && cmd_ok && !pending) begin
            pending   <= 1'b1;
            cmd.rd    <= bus_wdata[2];
            cmd.phy   <= bus_wdata[29:25];
            cmd.regad <= bus_wdata[24:20];
            cmd.wdata <= bus_wdata[19:4];
        end
    end

    // Prescale register: zero is rejected so MDC never stalls.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prescale <= PRESC_RST;
        else if (bus_wr && bus_addr == A_CFG && bus_wdata[PRESC_W-1:0] != '0)
            prescale <= bus_wdata[PRESC_W-1:0];
    end

    // Result register: cleared when a command starts, loaded when a read ends.
    always_ff @(posedge clk) begin
        if (!rst_n)
            result_q <= '0;
        else if (start)
            result_q <= '0;
        else if (eng_done_rd)
            result_q <= {eng_err, eng_err, eng_rdata};
    end

    // Read multiplexer over the mapped words.
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            A_STATUS: rd_mux = {28'd0, eng_busy, pending, 2'b00};
            A_CMD:    rd_mux = {1'b1, 1'b0, cmd.phy, cmd.regad, cmd.wdata,
                                1'b0, cmd.rd, !cmd.rd, 1'b0};
            A_DATA:   rd_mux = {{(32-RES_W){1'b0}}, result_q};
            A_CFG:    rd_mux = {{(32-PRESC_W){1'b0}}, prescale};
            default:  rd_mux = '0;
        endcase
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_mux;
    end

    p_pending_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !start) |=> (pending && $stable(cmd)));
    p_prescale_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        prescale != '0);
    p_err_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        result_q[RES_W-1] == result_q[RES_W-2]);
endmodule

// File: rtl/mdio_clkgen.sv
// MDC generator. Captures the prescale value at frame start and toggles MDC
// every N+1 clocks while a frame runs. Reports single-cycle rise/fall events.
module mdio_clkgen
    import mdio_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               busy,
    input  logic [PRESC_W-1:0] prescale,
    output logic               mdc,
    output logic               rise,
    output logic               fall
);
    logic [PRESC_W-1:0] cnt;
    logic [PRESC_W-1:0] presc_q;
    logic               edge_evt;

    assign edge_evt = busy && !start && (cnt == presc_q);
    assign rise     = edge_evt && !mdc;
    assign fall     = edge_evt && mdc;

    // Half-period counter and MDC level; idle low outside a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            mdc     <= 1'b0;
            presc_q <= 8'd1;
        end else if (start) begin
            cnt     <= '0;
            mdc     <= 1'b0;
            presc_q <= prescale;
        end else if (busy) begin
            if (edge_evt) begin
                cnt <= '0;
                mdc <= !mdc;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            cnt <= '0;
            mdc <= 1'b0;
        end
    end

    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt <= presc_q));
endmodule

// File: rtl/mdio_frame_engine.sv
// Frame serialiser. Loads a 64-bit frame at start, shifts one bit per MDC
// falling edge, samples MDIO on rising edges during a read, and releases
// the line from the turnaround onward. Assumes rise/fall events alternate.
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mdio_cmd_t         cmd,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done_rd,
    output logic              err,
    output logic [DATA_W-1:0] rdata
);
    localparam int K_W = $clog2(FRAME_LEN);
    localparam logic [K_W-1:0] K_LAST = K_W'(FRAME_LEN - 1);
    localparam logic [K_W-1:0] K_REL  = K_W'(REL_IDX);
    localparam logic [K_W-1:0] K_TA2  = K_W'(TA2_IDX);
    localparam logic [K_W-1:0] K_DAT  = K_W'(DAT_IDX);

    logic [FRAME_LEN-1:0] frame;
    logic [FRAME_LEN-1:0] shift_q;
    logic [K_W-1:0]       k;
    logic                 is_rd;

    // Frame image built from the queued command.
    always_comb begin
        frame = {{PRE_LEN{1'b1}}, 2'b01,
                 cmd.rd ? 2'b10 : 2'b01,
                 cmd.phy, cmd.regad,
                 cmd.rd ? 2'b11 : 2'b10,
                 cmd.rd ? {DATA_W{1'b1}} : cmd.wdata};
    end

    assign mdio_o  = busy ? shift_q[FRAME_LEN-1] : 1'b1;
    assign mdio_oe = busy && !(is_rd && k >= K_REL);
    assign done_rd = fall && (k == K_LAST) && is_rd;

    // Bit sequencing: load, advance on falling MDC, end after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            k       <= '0;
            shift_q <= '0;
            is_rd   <= 1'b0;
        end else if (start) begin
            busy    <= 1'b1;
            k       <= '0;
            shift_q <= frame;
            is_rd   <= cmd.rd;
        end else if (fall) begin
            if (k == K_LAST) begin
                busy <= 1'b0;
            end else begin
                k       <= k + 1'b1;
                shift_q <= {shift_q[FRAME_LEN-2:0], 1'b0};
            end
        end
    end

    // Read capture on rising MDC: turnaround check, then data MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err   <= 1'b0;
            rdata <= '0;
        end else if (start) begin
            err   <= 1'b0;
            rdata <= '0;
        end else if (rise && is_rd) begin
            if (k == K_TA2)
                err <= mdio_i;
            else if (k >= K_DAT)
                rdata <= {rdata[DATA_W-2:0], mdio_i};
        end
    end

    p_bit_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fall) |=> $stable(mdio_o));
endmodule

// File: rtl/mdio_master.sv
// Top of the management-bus master: register bank, MDC generator and
// frame serialiser. Assumes an external tri-state buffer driven by mdio_oe.
module mdio_master
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic               start;
    mdio_cmd_t          cmd;
    logic [PRESC_W-1:0] prescale;
    logic               eng_busy;
    logic               done_rd;
    logic               err;
    logic [DATA_W-1:0]  rdata;
    logic               rise;
    logic               fall;

    mdio_regbank u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_busy(eng_busy), .eng_done_rd(done_rd), .eng_err(err),
        .eng_rdata(rdata), .start(start), .cmd(cmd), .prescale(prescale)
    );

    mdio_clkgen u_clk (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(eng_busy),
        .prescale(prescale), .mdc(mdc), .rise(rise), .fall(fall)
    );

    mdio_frame_engine u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
        .rise(rise), .fall(fall), .mdio_i(mdio_i), .busy(eng_busy),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done_rd(done_rd),
        .err(err), .rdata(rdata)
    );

    p_mdc_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> !mdc);
    p_frame_opens_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (mdio_oe && mdio_o && !mdc));
endmodule

// File: tb/sim_mdio_master.sv
// Bench: a PHY model answers reads, and every frame is captured at MDC
// rising edges and compared with a frame computed from the command fields.
module sim_mdio_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int fails = 0;
    bit done_flag = 0;

    // PHY model / monitor state
    logic [63:0] cap = '0;
    logic [63:0] frames [8];
    int          fcnt = 0;
    int          nb = 0;
    int          hicnt = 0;
    int          oe_bad = 0;
    bit          cur_rd = 0;
    bit          mdc_prev = 0;
    bit          phy_ok = 1;
    logic [15:0] resp = '0;

    mdio_master u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #2.5 clk = ~clk;

    function automatic logic [31:0] cmd_word(bit rd, logic [4:0] phy,
                                             logic [4:0] ra, logic [15:0] wd);
        return {1'b1, 1'b0, phy, ra, wd, 1'b0, rd, !rd, 1'b0};
    endfunction

    function automatic logic [63:0] exp_frame(bit rd, logic [4:0] phy,
                                              logic [4:0] ra, logic [15:0] wd);
        return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, ra,
                rd ? 2'b11 : 2'b10, rd ? 16'hFFFF : wd};
    endfunction

    function automatic logic [63:0] frame_mask(bit rd);
        return rd ? 64'hFFFF_FFFF_FFFF_C000 : 64'hFFFF_FFFF_FFFF_FFFF;
    endfunction

    function automatic logic [31:0] exp_result(bit rd, bit ok, logic [15:0] r);
        if (!rd) return 32'd0;
        return ok ? {16'd0, r} : 32'h0003_FFFF;
    endfunction

    task automatic check(input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        do bus_read(3'd0, s); while (s[3:2] != 2'b00);
    endtask

    // Monitor and PHY model, evaluated away from the active clock edge.
    always @(negedge clk) begin
        if (mdc && !mdc_prev) begin
            cap[63-nb] = mdio_o;
            if (nb == 35) cur_rd = (cap[63-34] == 1'b1) && (cap[63-35] == 1'b0);
            if (mdio_oe !== !(cur_rd && nb >= 46)) oe_bad++;
            if (nb == 63) begin
                frames[fcnt % 8] = cap;
                fcnt++;
                nb = 0;
                cur_rd = 0;
            end else begin
                nb++;
            end
        end
        if (!mdc && mdc_prev) begin
            if (nb == 47) mdio_i = phy_ok ? 1'b0 : 1'b1;
            else if (nb >= 48 && phy_ok) mdio_i = resp[63-nb];
            else mdio_i = 1'b1;
        end
        if (mdc) hicnt++;
        mdc_prev = mdc;
    end

    task automatic run_txn(bit rd, logic [4:0] phy, logic [4:0] ra,
                           logic [15:0] wd, logic [7:0] presc);
        logic [31:0] d;
        int f0;
        bus_write(3'd4, {24'd0, presc});
        bus_read(3'd4, d);
        check("R10 prescale readback", d, {24'd0, presc});
        f0 = fcnt; hicnt = 0; oe_bad = 0;
        bus_write(3'd2, cmd_word(rd, phy, ra, wd));
        wait_idle();
        check("R5 one frame per command", fcnt, f0 + 1);
        check(rd ? "R7 read frame bits" : "R6 write frame bits",
              frames[f0 % 8] & frame_mask(rd),
              exp_frame(rd, phy, ra, wd) & frame_mask(rd));
        check(rd ? "R7 output release pattern" : "R6 output enable held",
              oe_bad, 0);
        check("R9 MDC high clocks per frame", hicnt, 64 * (presc + 1));
        bus_read(3'd3, d);
        check(rd ? "R7 R8 read result" : "R8 result cleared on write",
              d, exp_result(rd, phy_ok, resp));
    endtask

    initial begin
        logic [31:0] d;
        int f0;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 mdc low", mdc, 0);
        check("R1 oe low", mdio_oe, 0);
        bus_read(3'd0, d); check("R1 status zero", d, 0);
        bus_read(3'd4, d); check("R1 prescale default", d, 4);
        bus_read(3'd3, d); check("R1 result zero", d, 0);
        // R2 unmapped index
        bus_read(3'd1, d); check("R2 unmapped reads zero", d, 0);
        bus_read(3'd7, d); check("R2 unmapped reads zero", d, 0);

        // R10 zero prescale rejected
        bus_write(3'd4, 32'd3);
        bus_write(3'd4, 32'h0000_0100);
        bus_read(3'd4, d); check("R10 zero prescale ignored", d, 3);

        // R3 malformed commands ignored
        f0 = fcnt;
        bus_write(3'd2, cmd_word(1, 5'd3, 5'd4, 16'h0) & 32'h7FFF_FFFF);
        bus_read(3'd0, d); check("R3 valid bit clear ignored", d, 0);
        bus_write(3'd2, cmd_word(0, 5'd3, 5'd4, 16'h1234) | 32'h4);
        bus_read(3'd0, d); check("R3 both ops ignored", d, 0);
        bus_write(3'd2, cmd_word(0, 5'd3, 5'd4, 16'h1234) & ~32'h6);
        bus_read(3'd0, d); check("R3 no op ignored", d, 0);
        repeat (300) @(negedge clk);
        check("R3 no frame from bad commands", fcnt, f0);
        check("R9 mdc idle low", mdc, 0);

        // Directed write and read, smallest prescale
        phy_ok = 1; resp = 16'hA5C3;
        run_txn(0, 5'd31, 5'd0, 16'hBEEF, 8'd1);
        run_txn(1, 5'd0, 5'd31, 16'h0, 8'd1);

        // R8 missing PHY, then cleared by next command
        phy_ok = 0;
        run_txn(1, 5'd9, 5'd17, 16'h0, 8'd2);
        phy_ok = 1;
        run_txn(0, 5'd9, 5'd17, 16'h0F0F, 8'd2);

        // R4 R5 queueing while a frame runs
        bus_write(3'd4, 32'd1);
        f0 = fcnt;
        resp = 16'h5A17;
        bus_write(3'd2, cmd_word(0, 5'd1, 5'd2, 16'h1111));
        do bus_read(3'd0, d); while (d[3] == 1'b0);
        bus_write(3'd2, cmd_word(1, 5'd6, 5'd7, 16'h0));
        bus_read(3'd0, d); check("R5 waiting held during frame", d, 32'hC);
        bus_write(3'd2, cmd_word(0, 5'd12, 5'd13, 16'h2222));
        bus_read(3'd2, d);
        check("R4 second command not overwritten", d,
              cmd_word(1, 5'd6, 5'd7, 16'h0));
        wait_idle();
        check("R5 queued command ran", fcnt, f0 + 2);
        check("R4 R5 queued frame content",
              frames[(f0 + 1) % 8] & frame_mask(1),
              exp_frame(1, 5'd6, 5'd7, 16'h0) & frame_mask(1));
        bus_read(3'd3, d); check("R7 queued read result", d, {16'd0, resp});
        repeat (400) @(negedge clk);
        check("R4 ignored command never ran", fcnt, f0 + 2);

        // Random transactions
        for (int i = 0; i < 16; i++) begin
            bit rd;
            logic [4:0] ph, ra;
            logic [15:0] wd;
            logic [7:0] pr;
            rd = 1'($urandom % 2);
            ph = 5'($urandom); ra = 5'($urandom); wd = 16'($urandom);
            pr = 8'(1 + $urandom % 5);
            resp = 16'($urandom);
            phy_ok = ($urandom % 4) != 0;
            run_txn(rd, ph, ra, wd, pr);
        end

        if (!done_flag) begin
            done_flag = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule